// File: doc/BRIEF.md
# Tournament Branch Direction Predictor with Speculative History Repair

This block predicts whether a conditional branch is taken. It holds three tables of saturating counters. A local table is indexed by the recent outcomes of the branch itself. A global table is indexed by the recent outcomes of all branches. A choice table decides which of the two to believe. The fetch stage presents a PC and a flag that says whether the target buffer hit. In the same cycle the block returns a direction and a checkpoint tag. Both histories move forward speculatively in that fetch cycle.

Later, the commit stage sends back the tag of the oldest branch and its real outcome, and the counters are trained from the state saved at fetch. A squash port names a mispredicted branch and gives its correct outcome. The block then rebuilds the histories as they stood just after that branch, with the right bit in place of the wrong guess. Every checkpoint younger than that branch is dropped.

The designer sets these as parameters: the length of each history, the index width of each table, the width of each counter and the checkpoint depth. The local counter table has 2^LHIST_LEN entries.

Top module: `tournament_bp`

## Requirements
- R1: After reset both histories are zero. Every counter sits at its weakly-not-taken value, 2^(W-1)-1. The checkpoint buffer is empty, the next tag is 0 and ckpt_full is 0. So the first prediction for a hit branch is not-taken.
- R2: Each table decides taken when its counter is at least 2^(W-1), where W is that table's own counter width: LCTR_W, GCTR_W or CCTR_W. Counters saturate at 0 and 2^W-1.
- R3: When the choice counter reads taken, the output direction is the global table's decision. Otherwise it is the local table's decision.
- R4: When pred_btb_hit is 0, pred_taken is 0. A 0 is then shifted into both the global history and the branch's local history.
- R5: Each accepted prediction shifts the bit it output into bit 0 of the global history. The same bit is shifted into the local history entry selected by that PC, in the same clock edge.
- R6: Each table takes its index from the history it uses. The global table uses the low GIDX_W bits of the global history and the choice table uses the low CIDX_W bits. When the history is shorter than the index, the missing bits read as zero. The local counter table uses the whole local history. The local history entry is chosen by pred_pc[PC_SHIFT+LHT_W-1:PC_SHIFT].
- R7: An accepted prediction is given the next tag in order, counting modulo CKPT_DEPTH. ckpt_full is 1 while CKPT_DEPTH checkpoints are outstanding. A prediction made while the buffer is full is ignored: no tag is used and neither history changes.
- R8: An update trains the local and global counters one step toward the actual outcome. It uses the indices saved at fetch. The choice counter is trained only when the two saved component decisions differ. It steps up if the global decision was right and down otherwise.
- R9: A squash sets the global history to the checkpointed prior history shifted left with sq_taken in bit 0. The checkpointed local entry is rebuilt the same way. All younger checkpoints are dropped, so the next tag is sq_tag+1. A prediction in the squash cycle is ignored.
- R10: When an update and a prediction arrive in the same cycle, the prediction reads the counters as already trained by that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_valid | input | 1 | Fetch-time prediction request |
| pred_pc | input | PC_W | Branch PC |
| pred_btb_hit | input | 1 | The target buffer holds this branch |
| pred_taken | output | 1 | Predicted direction (combinational) |
| pred_tag | output | $clog2(CKPT_DEPTH) | Tag given to this prediction |
| ckpt_full | output | 1 | Checkpoint buffer full; predictions are ignored |
| upd_valid | input | 1 | Commit of the oldest outstanding branch |
| upd_tag | input | $clog2(CKPT_DEPTH) | Tag of the committing branch |
| upd_taken | input | 1 | Resolved outcome at commit |
| sq_valid | input | 1 | Squash after a misprediction |
| sq_tag | input | $clog2(CKPT_DEPTH) | Tag of the mispredicted branch |
| sq_taken | input | 1 | Correct outcome of that branch |

## Verification
pred_taken, pred_tag and ckpt_full are combinational in the cycle a request is presented. They read state written at the previous edge. So the bench drives inputs at the falling edge and samples the outputs one nanosecond later, in the same cycle. Training from an update is already visible to a prediction in that cycle. A history shift or a squash repair first affects the prediction one cycle later. The bench's reference model applies the update, then the squash, then the prediction, in the order the requirements state, before it computes each expected value. It advances its own state only after the comparison, so every expected value lines up with the edge at which the design commits.

// File: rtl/tbp_pkg.sv
// Shared helpers for the tournament predictor: saturating counter step
// and the weakly-not-taken reset value. Counter widths up to 8 bits.
package tbp_pkg;

    // One saturating step of a W-bit counter toward up/down.
    function automatic logic [7:0] sat_step(input logic [7:0] v, input logic up,
                                            input int unsigned w);
        logic [7:0] top_v;
        top_v = 8'((1 << w) - 1);
        if (up)
            return (v == top_v) ? v : v + 8'd1;
        else
            return (v == 8'd0) ? v : v - 8'd1;
    endfunction

    // Weakly-not-taken value of a W-bit counter.
    function automatic logic [7:0] weak_nt(input int unsigned w);
        return 8'((1 << (w - 1)) - 1);
    endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
// Table of saturating counters with one read port and one train port.
// A read of the entry being trained in the same cycle sees the trained
// value. Assumes CTR_W <= 8.
module tbp_ctr_table #(
    parameter int IDX_W = 10,
    parameter int CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    import tbp_pkg::*;

    localparam int               ENTRIES = 1 << IDX_W;
    localparam logic [CTR_W-1:0] INIT_V  = CTR_W'(weak_nt(CTR_W));

    logic [CTR_W-1:0] ctr_q [ENTRIES];
    logic [CTR_W-1:0] wr_cur, wr_nxt, rd_val;

    // Trained value of the entry being written.
    always_comb begin
        wr_cur = ctr_q[wr_idx];
        wr_nxt = CTR_W'(sat_step(8'(wr_cur), wr_up, CTR_W));
    end

    // Read with forwarding from the same-cycle update.
    always_comb begin
        rd_val   = (wr_en && (wr_idx == rd_idx)) ? wr_nxt : ctr_q[rd_idx];
        rd_taken = rd_val[CTR_W-1];
    end

    // Counter storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= INIT_V;
        end else if (wr_en) begin
            ctr_q[wr_idx] <= wr_nxt;
        end
    end

    // R8
    train_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up) |=> (ctr_q[$past(wr_idx)] >= $past(wr_cur)));
    // R8
    train_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_up) |=> (ctr_q[$past(wr_idx)] <= $past(wr_cur)));
    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((ctr_q[$past(wr_idx)] == $past(wr_cur)) ||
                   (ctr_q[$past(wr_idx)] == CTR_W'($past(wr_cur) + 1'b1)) ||
                   (ctr_q[$past(wr_idx)] == CTR_W'($past(wr_cur) - 1'b1))));

endmodule

// File: rtl/tbp_lhist_table.sv
// Per-branch local history registers, indexed by PC bits. One
// combinational read port and one write port. Cleared to zero on reset.
module tbp_lhist_table #(
    parameter int LHT_W = 5,
    parameter int LH_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LHT_W-1:0] rd_idx,
    output logic [LH_W-1:0]  rd_hist,
    input  logic             wr_en,
    input  logic [LHT_W-1:0] wr_idx,
    input  logic [LH_W-1:0]  wr_hist
);
    localparam int ENTRIES = 1 << LHT_W;

    logic [LH_W-1:0] hist_q [ENTRIES];

    // Combinational read of the selected entry.
    assign rd_hist = hist_q[rd_idx];

    // History storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) hist_q[i] <= '0;
        end else if (wr_en) begin
            hist_q[wr_idx] <= wr_hist;
        end
    end

endmodule

// File: rtl/tbp_ckpt_buf.sv
// In-order checkpoint buffer. Push at the tail, pop at the head, and on a
// squash cut the tail back to just after the squashed entry. Assumes
// DEPTH is a power of two, >= 2. Pops arrive in order, and a pop and a
// squash never name the same entry.
module tbp_ckpt_buf #(
    parameter int DEPTH = 8,
    parameter int ENT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [ENT_W-1:0]         push_data,
    output logic [$clog2(DEPTH)-1:0] tail_tag,
    output logic                     full,
    input  logic                     pop,
    input  logic [$clog2(DEPTH)-1:0] pop_tag,
    output logic [ENT_W-1:0]         pop_data,
    input  logic                     sq,
    input  logic [$clog2(DEPTH)-1:0] sq_tag,
    output logic [ENT_W-1:0]         sq_data
);
    localparam int TW = $clog2(DEPTH);
    localparam int CW = TW + 1;

    logic [ENT_W-1:0] ent_q [DEPTH];
    logic [TW-1:0]    head_q, tail_q;
    logic [CW-1:0]    count_q;
    logic [TW-1:0]    sq_dist;

    // Read ports and status.
    always_comb begin
        pop_data = ent_q[pop_tag];
        sq_data  = ent_q[sq_tag];
        tail_tag = tail_q;
        full     = (count_q == CW'(DEPTH));
        sq_dist  = sq_tag - head_q;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            head_q <= head_q + TW'(pop);
            if (sq) begin
                tail_q  <= sq_tag + TW'(1);
                count_q <= {1'b0, sq_dist} + CW'(1) - CW'(pop);
            end else begin
                tail_q  <= tail_q + TW'(push);
                count_q <= count_q + CW'(push) - CW'(pop);
            end
        end
    end

    // Entry storage written at the tail.
    always_ff @(posedge clk) begin
        if (push) ent_q[tail_q] <= push_data;
    end

    // R7
    occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));
    // R7
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    // R8
    pop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> ((count_q != '0) && (pop_tag == head_q)));
    // R9
    squash_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq && !pop) |=> (count_q <= $past(count_q)));

endmodule

// File: rtl/tournament_bp.sv
// Tournament branch direction predictor. A choice table selects between a
// local-history and a global-history counter table. Histories advance
// speculatively at fetch, are checkpointed per prediction, and are
// repaired on a squash. Training happens at commit from the checkpoint.
// Assumes GHIST_LEN >= 2 and LHIST_LEN >= 2, commit in program order,
// and no prediction request that relies on being accepted during a squash.
module tournament_bp #(
    parameter int PC_W       = 32,
    parameter int PC_SHIFT   = 2,
    parameter int GHIST_LEN  = 12,
    parameter int GIDX_W     = 10,
    parameter int CIDX_W     = 9,
    parameter int LHIST_LEN  = 6,
    parameter int LHT_W      = 5,
    parameter int LCTR_W     = 3,
    parameter int GCTR_W     = 2,
    parameter int CCTR_W     = 2,
    parameter int CKPT_DEPTH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pred_valid,
    input  logic [PC_W-1:0]               pred_pc,
    input  logic                          pred_btb_hit,
    output logic                          pred_taken,
    output logic [$clog2(CKPT_DEPTH)-1:0] pred_tag,
    output logic                          ckpt_full,
    input  logic                          upd_valid,
    input  logic [$clog2(CKPT_DEPTH)-1:0] upd_tag,
    input  logic                          upd_taken,
    input  logic                          sq_valid,
    input  logic [$clog2(CKPT_DEPTH)-1:0] sq_tag,
    input  logic                          sq_taken
);
    localparam int TAG_W = $clog2(CKPT_DEPTH);
    localparam int XW0   = (GHIST_LEN > GIDX_W) ? GHIST_LEN : GIDX_W;
    localparam int XW    = (XW0 > CIDX_W) ? XW0 : CIDX_W;
    localparam int ENT_W = GHIST_LEN + LHIST_LEN + LHT_W + 2;

    // Fields of a checkpoint entry.
    typedef struct packed {
        logic [GHIST_LEN-1:0] g_prior;
        logic [LHIST_LEN-1:0] l_prior;
        logic [LHT_W-1:0]     l_idx;
        logic                 l_pred;
        logic                 g_pred;
    } ckpt_t;

    logic [GHIST_LEN-1:0] ghist_q;
    logic [XW-1:0]        ghist_x, upd_g_x;
    logic [LHT_W-1:0]     lht_idx;
    logic [LHIST_LEN-1:0] lhist_rd;
    logic                 l_taken, g_taken, c_taken, dir;
    logic                 pred_acc;
    ckpt_t                push_ent, upd_ent, sq_ent;
    logic [ENT_W-1:0]     upd_raw, sq_raw;
    logic                 lht_we;
    logic [LHT_W-1:0]     lht_widx;
    logic [LHIST_LEN-1:0] lht_wdata;
    logic                 choice_we, choice_up;

    // Index formation from the live and checkpointed global history.
    always_comb begin
        ghist_x = XW'(ghist_q);
        upd_ent = ckpt_t'(upd_raw);
        sq_ent  = ckpt_t'(sq_raw);
        upd_g_x = XW'(upd_ent.g_prior);
        lht_idx = pred_pc[PC_SHIFT +: LHT_W];
    end

    tbp_lhist_table #(.LHT_W(LHT_W), .LH_W(LHIST_LEN)) u_lht (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (lht_idx),
        .rd_hist (lhist_rd),
        .wr_en   (lht_we),
        .wr_idx  (lht_widx),
        .wr_hist (lht_wdata)
    );

    tbp_ctr_table #(.IDX_W(LHIST_LEN), .CTR_W(LCTR_W)) u_local (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lhist_rd),
        .rd_taken (l_taken),
        .wr_en    (upd_valid),
        .wr_idx   (upd_ent.l_prior),
        .wr_up    (upd_taken)
    );

    tbp_ctr_table #(.IDX_W(GIDX_W), .CTR_W(GCTR_W)) u_global (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (ghist_x[GIDX_W-1:0]),
        .rd_taken (g_taken),
        .wr_en    (upd_valid),
        .wr_idx   (upd_g_x[GIDX_W-1:0]),
        .wr_up    (upd_taken)
    );

    tbp_ctr_table #(.IDX_W(CIDX_W), .CTR_W(CCTR_W)) u_choice (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (ghist_x[CIDX_W-1:0]),
        .rd_taken (c_taken),
        .wr_en    (choice_we),
        .wr_idx   (upd_g_x[CIDX_W-1:0]),
        .wr_up    (choice_up)
    );

    tbp_ckpt_buf #(.DEPTH(CKPT_DEPTH), .ENT_W(ENT_W)) u_ckpt (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (pred_acc),
        .push_data (push_ent),
        .tail_tag  (pred_tag),
        .full      (ckpt_full),
        .pop       (upd_valid),
        .pop_tag   (upd_tag),
        .pop_data  (upd_raw),
        .sq        (sq_valid),
        .sq_tag    (sq_tag),
        .sq_data   (sq_raw)
    );

    // Direction choice; a target buffer miss forces not-taken.
    always_comb begin
        dir        = c_taken ? g_taken : l_taken;
        pred_taken = pred_btb_hit & dir;
        pred_acc   = pred_valid && !sq_valid && !ckpt_full;
        push_ent   = '{g_prior: ghist_q, l_prior: lhist_rd, l_idx: lht_idx,
                       l_pred: l_taken, g_pred: g_taken};
    end

    // Choice training only on component disagreement.
    always_comb begin
        choice_we = upd_valid && (upd_ent.l_pred != upd_ent.g_pred);
        choice_up = (upd_ent.g_pred == upd_taken);
    end

    // Local history write: squash repair first, else speculative shift.
    always_comb begin
        lht_we    = 1'b0;
        lht_widx  = lht_idx;
        lht_wdata = {lhist_rd[LHIST_LEN-2:0], pred_taken};
        if (sq_valid) begin
            lht_we    = 1'b1;
            lht_widx  = sq_ent.l_idx;
            lht_wdata = {sq_ent.l_prior[LHIST_LEN-2:0], sq_taken};
        end else if (pred_acc) begin
            lht_we = 1'b1;
        end
    end

    // Global history register: repair on squash, shift on prediction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ghist_q <= '0;
        end else if (sq_valid) begin
            ghist_q <= {sq_ent.g_prior[GHIST_LEN-2:0], sq_taken};
        end else if (pred_acc) begin
            ghist_q <= {ghist_q[GHIST_LEN-2:0], pred_taken};
        end
    end

    // R4
    miss_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && !pred_btb_hit) |-> !pred_taken);
    // R5
    ghist_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_acc |=> (ghist_q[0] == $past(pred_taken)));
    // R9
    ghist_repair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |=> ((ghist_q[0] == $past(sq_taken)) &&
                      (ghist_q[GHIST_LEN-1:1] == $past(sq_ent.g_prior[GHIST_LEN-2:0]))));
    // R9
    sq_next_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |=> (pred_tag == TAG_W'($past(sq_tag) + 1'b1)));
    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ckpt_full && !upd_valid && !sq_valid) |=> $stable(pred_tag));

endmodule

// File: tb/sim_tournament_bp.sv
// Self-checking bench with a behavioural reference model, compared every cycle.
module sim_tournament_bp;

    localparam int D = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pred_valid = 1'b0;
    logic [31:0] pred_pc = '0;
    logic       pred_btb_hit = 1'b0;
    logic       pred_taken;
    logic [2:0] pred_tag;
    logic       ckpt_full;
    logic       upd_valid = 1'b0;
    logic [2:0] upd_tag = '0;
    logic       upd_taken = 1'b0;
    logic       sq_valid = 1'b0;
    logic [2:0] sq_tag = '0;
    logic       sq_taken = 1'b0;

    always #4 clk = ~clk;

    tournament_bp u0 (
        .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc),
        .pred_btb_hit(pred_btb_hit), .pred_taken(pred_taken), .pred_tag(pred_tag),
        .ckpt_full(ckpt_full), .upd_valid(upd_valid), .upd_tag(upd_tag),
        .upd_taken(upd_taken), .sq_valid(sq_valid), .sq_tag(sq_tag), .sq_taken(sq_taken)
    );

    int checks = 0;
    int failures = 0;

    // Reference model state.
    typedef struct { int g; int l; int li; int lp; int gp; } ent_t;
    ent_t q[$];
    bit   act[$];
    int   head_tag = 0;
    int   ghist = 0;
    int   lht[32];
    int   ltab[64];
    int   gtab[1024];
    int   ctab[512];

    function automatic int sat(input int v, input bit up, input int w);
        if (up) return (v == (1 << w) - 1) ? v : v + 1;
        return (v == 0) ? v : v - 1;
    endfunction

    function automatic bit tk(input int v, input int w);
        return v >= (1 << (w - 1));
    endfunction

    task automatic check_int(input string req, input string what, input int a, input int e);
        checks++;
        if (a != e) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, a, e);
        end
    endtask

    task automatic model_reset();
        q.delete(); act.delete();
        head_tag = 0; ghist = 0;
        foreach (lht[i])  lht[i]  = 0;
        foreach (ltab[i]) ltab[i] = 3;
        foreach (gtab[i]) gtab[i] = 1;
        foreach (ctab[i]) ctab[i] = 1;
    endtask

    // One clock cycle: drive, compare against the model, advance the model.
    task automatic step(input bit pv, input int pc, input bit hit, input bit actual,
                        input bit uv, input bit sv, input int stag, input bit st,
                        input string req, output bit exp_t, output bit accepted);
        ent_t se;
        int li, lh, tail, p;
        bit lp, gp, ch, full_o;
        @(negedge clk);
        pred_valid = pv; pred_pc = pc; pred_btb_hit = hit;
        upd_valid = uv; upd_tag = 3'(head_tag); upd_taken = uv ? act[0] : 1'b0;
        sq_valid = sv; sq_tag = 3'(stag); sq_taken = st;
        #1;
        full_o = (q.size() == D);
        tail = (head_tag + q.size()) % D;
        if (sv) se = q[(stag - head_tag + D) % D];
        if (uv) begin
            ent_t e;
            e = q[0];
            ltab[e.l] = sat(ltab[e.l], act[0], 3);
            gtab[e.g % 1024] = sat(gtab[e.g % 1024], act[0], 2);
            if (e.lp != e.gp) ctab[e.g % 512] = sat(ctab[e.g % 512], (e.gp == act[0]), 2);
            void'(q.pop_front()); void'(act.pop_front());
            head_tag = (head_tag + 1) % D;
        end
        li = (pc >> 2) & 31;
        lh = lht[li];
        lp = tk(ltab[lh], 3);
        gp = tk(gtab[ghist % 1024], 2);
        ch = tk(ctab[ghist % 512], 2);
        exp_t = hit && (ch ? gp : lp);
        if (pv) check_int(req, "pred_taken", int'(pred_taken), int'(exp_t));
        check_int("R7", "pred_tag", int'(pred_tag), tail);
        check_int("R7", "ckpt_full", int'(ckpt_full), int'(full_o));
        accepted = 1'b0;
        if (sv) begin
            ghist = ((se.g << 1) | int'(st)) & 4095;
            lht[se.li] = ((se.l << 1) | int'(st)) & 63;
            p = (stag - head_tag + D) % D;
            while (q.size() > p + 1) begin void'(q.pop_back()); void'(act.pop_back()); end
        end else if (pv && !full_o) begin
            q.push_back('{ghist, lh, li, int'(lp), int'(gp)});
            act.push_back(actual);
            ghist = ((ghist << 1) | int'(exp_t)) & 4095;
            lht[li] = ((lh << 1) | int'(exp_t)) & 63;
            accepted = 1'b1;
        end
        @(posedge clk);
    endtask

    // Random traffic with pc-dependent outcome patterns.
    task automatic run_random(input int n, input string req, input int pcbase);
        bit et, acc, pend, pact;
        int ptag, ctr0;
        pend = 0; ptag = 0; pact = 0; ctr0 = 0;
        for (int i = 0; i < n; i++) begin
            if (pend) begin
                step($urandom % 2, pcbase, 1'b1, 1'b0, 1'b0, 1'b1, ptag, pact, "R9", et, acc);
                pend = 0;
            end else begin
                int sel, pc;
                bit pv, uv, hit, a;
                sel = $urandom % 4;
                pc = pcbase + sel * 4;
                ctr0++;
                case (sel)
                    0: a = 1'b1;
                    1: a = ctr0[0];
                    2: a = (ctr0 % 3) != 0;
                    default: a = $urandom % 2;
                endcase
                hit = ($urandom % 8) != 0;
                pv = ($urandom % 4) != 0;
                uv = (act.size() > 0) && ((act.size() == D) || ($urandom % 2));
                ptag = (head_tag + q.size() - (uv ? 0 : 0)) % D;
                step(pv, pc, hit, a, uv, 1'b0, 0, 1'b0, req, et, acc);
                if (acc) begin
                    ptag = (head_tag + q.size() - 1) % D;
                    if (et != a) begin pend = 1; pact = a; end
                end
            end
        end
        while (act.size() > 0)
            step(1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b0, req, et, acc);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        bit et, acc;
        int t0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R1 reset state at the ports
        check_int("R1", "pred_tag after reset", int'(pred_tag), 0);
        check_int("R1", "ckpt_full after reset", int'(ckpt_full), 0);
        rst_n = 1'b1;

        // R1 first prediction of a hit branch is not-taken
        step(1, 32'h100, 1, 1, 0, 0, 0, 0, "R1", et, acc);
        check_int("R1", "first prediction", int'(pred_taken), 0);
        // R8 repeated training of the same branch toward taken
        for (int i = 0; i < 6; i++) step(1, 32'h100, 1, 1, 1, 0, 0, 0, "R8", et, acc);
        step(0, 0, 0, 0, 1, 0, 0, 0, "R8", et, acc);
        for (int i = 0; i < 4; i++) begin
            step(1, 32'h100, 1, 1, 0, 0, 0, 0, "R8", et, acc);
            step(0, 0, 0, 0, 1, 0, 0, 0, "R8", et, acc);
        end

        // R4 miss forces not-taken even with trained counters
        step(1, 32'h100, 0, 0, 0, 0, 0, 0, "R4", et, acc);
        check_int("R4", "miss direction", int'(pred_taken), 0);
        step(1, 32'h100, 1, 1, 1, 0, 0, 0, "R4", et, acc);
        step(0, 0, 0, 0, 1, 0, 0, 0, "R4", et, acc);

        // R5 alternating branches move both histories
        for (int i = 0; i < 12; i++) step(1, 32'h200 + (i % 3) * 4, 1, i[0], act.size() > 3, 0, 0, 0, "R5", et, acc);
        while (act.size() > 0) step(0, 0, 0, 0, 1, 0, 0, 0, "R5", et, acc);

        // R7 fill the checkpoint buffer, then a prediction while full
        for (int i = 0; i < D; i++) step(1, 32'h300, 1, 1, 0, 0, 0, 0, "R7", et, acc);
        @(negedge clk); #1;
        check_int("R7", "ckpt_full at depth", int'(ckpt_full), 1);
        t0 = int'(pred_tag);
        step(1, 32'h300, 1, 1, 0, 0, 0, 0, "R7", et, acc);
        check_int("R7", "ignored while full", int'(acc), 0);
        @(negedge clk); #1;
        check_int("R7", "tag held while full", int'(pred_tag), t0);
        while (act.size() > 0) step(0, 0, 0, 0, 1, 0, 0, 0, "R7", et, acc);

        // R9 squash of an older entry drops the younger ones
        t0 = (head_tag + q.size()) % D;
        for (int i = 0; i < 3; i++) step(1, 32'h400 + i * 4, 1, 1, 0, 0, 0, 0, "R9", et, acc);
        step(1, 32'h500, 1, 1, 0, 1, t0, 1, "R9", et, acc);
        @(negedge clk); #1;
        check_int("R9", "next tag after squash", int'(pred_tag), (t0 + 1) % D);
        step(1, 32'h400, 1, 1, 0, 0, 0, 0, "R9", et, acc);
        while (act.size() > 0) step(0, 0, 0, 0, 1, 0, 0, 0, "R9", et, acc);

        // Mixed traffic; each segment names the rule it stresses
        run_random(800, "R2", 32'h1000);
        run_random(800, "R3", 32'h2040);
        run_random(800, "R6", 32'h3000);
        run_random(800, "R10", 32'h4000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule